// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block connects an internal single-beat request port to an external asynchronous static RAM of 128K bytes. The RAM has two chip selects of opposite polarity, an output enable, a write enable, a 17-bit address and an 8-bit bidirectional data bus. The controller takes one request at a time through a valid/ready handshake. It registers the address and the write data. It then drives the RAM pins through a fixed sequence of phases, and the length of each phase is a whole number of clock cycles.

Each timing limit of the RAM is a parameter in nanoseconds. The controller converts it to cycles by ceiling division by the clock period, and no limit takes fewer than one cycle. The write pulse is long enough to meet the largest of three limits: the minimum pulse width, the data setup time before the end of the write, and the address setup time before the end of the write. A read holds the RAM selected with its outputs enabled for the longer of the access time and the read cycle time. The read data is captured on the last cycle of that window and returned with a one-cycle strobe. The controller drives the data bus only during writes, and it leaves turnaround gaps so that it never drives the bus at the same time as the RAM.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and after it is released, req_ready_o is 1, rsp_valid_o is 0, sram_we_no and sram_oe_no are 1, and the memory is deselected (sram_ce1_no = 1, sram_ce2_o = 0).
- R2: The memory is selected (sram_ce1_no = 0 and sram_ce2_o = 1) only during an accepted transfer. Outside a transfer both selects are at their inactive levels.
- R3: A write request (req_write_i = 1) is accepted on a rising edge where req_valid_i and req_ready_o are both 1. From the next cycle on, the controller drives the address, the select, sram_we_no = 0 and the write data, with sram_oe_no = 1. sram_we_no stays low for the write-pulse count, which is the largest of the ceilings of the pulse-width, data-setup and address-setup limits. With the default parameters this count is 2 cycles.
- R4: After the write pulse there are recovery cycles (at least 1) in which sram_we_no is 1 and the select, address and data stay as they were. In the following cycle the memory is deselected and the data bus is released.
- R5: A read request (req_write_i = 0) selects the memory with sram_oe_no = 0 and sram_we_no = 1 for the access count, which is the largest of the ceilings of the address-access, read-cycle and output-enable limits. With the default parameters this count is 2 cycles. The data bus is sampled on the last cycle of this window.
- R6: In the cycle after a read's access window, rsp_valid_o is 1 for exactly one cycle and rsp_rdata_o holds the sampled byte. In that same cycle the memory is deselected and sram_oe_no returns to 1.
- R7: req_ready_o is 0 from the accepting edge until the transfer, including its recovery or turnaround, is complete. With the default parameters it returns to 1 three cycles after the accepting edge, for both reads and writes.
- R8: The controller never drives the data bus while sram_oe_no is 0. After a read it leaves the bus released for the output-release count of cycles (1 with the default parameters). A read that follows a write finds the memory deselected for at least one cycle before sram_oe_no falls.
- R9: sram_addr_o is stable for as long as the memory stays selected within one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (17) | Word address |
| req_wdata_i | input | DATA_W (8) | Write data |
| rsp_valid_o | output | 1 | One-cycle strobe for read data |
| rsp_rdata_o | output | DATA_W (8) | Read data |
| sram_addr_o | output | ADDR_W (17) | Memory address pins |
| sram_ce1_no | output | 1 | Memory select, active low |
| sram_ce2_o | output | 1 | Memory select, active high |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write enable, active low |
| sram_data_io | inout | DATA_W (8) | Bidirectional memory data bus |

## Verification
Every request is accepted at a rising edge, E0. The select, the enables and the address change at E0 because they come from registers. With the default 10 ns clock, the write enable therefore rises at E0+2 and the memory is deselected at E0+3. For a read, the strobe and the data appear at E0+2, and ready returns at E0+3. Each task samples the pins at the falling edge in the middle of every cycle from E0 to E0+3 and compares them with these expected values. The memory model in the bench returns a poison byte during the first cycle of an output enable, so capturing the data one cycle early gives a wrong read result.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WPULSE,
    ST_WREC,
    ST_RACC,
    ST_RTURN
  } phase_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_data_port.sv
module sram_data_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sample_i,
  output logic [DATA_W-1:0] rdata_o,
  inout  wire  [DATA_W-1:0] bus_io
);

  assign bus_io = drive_i ? wdata_i : {DATA_W{1'bz}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (sample_i) rdata_o <= bus_io;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 10,
  parameter int T_WPULSE_NS  = 10,
  parameter int T_DSETUP_NS  = 8,
  parameter int T_ASETUP_NS  = 12,
  parameter int T_WCYCLE_NS  = 15,
  parameter int T_AACC_NS    = 15,
  parameter int T_RCYCLE_NS  = 15,
  parameter int T_OEACC_NS   = 7,
  parameter int T_RELEASE_NS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce1_no,
  output logic              sram_ce2_o,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  inout  wire  [DATA_W-1:0] sram_data_io
);

  localparam int WR_C   = max2(ns_to_cyc(T_WPULSE_NS, CLK_NS),
                          max2(ns_to_cyc(T_DSETUP_NS, CLK_NS), ns_to_cyc(T_ASETUP_NS, CLK_NS)));
  localparam int REC_C  = max2(1, ns_to_cyc(T_WCYCLE_NS, CLK_NS) - WR_C);
  localparam int RD_C   = max2(ns_to_cyc(T_AACC_NS, CLK_NS),
                          max2(ns_to_cyc(T_RCYCLE_NS, CLK_NS), ns_to_cyc(T_OEACC_NS, CLK_NS)));
  localparam int REL_C  = ns_to_cyc(T_RELEASE_NS, CLK_NS);
  localparam int MAX_C  = max2(max2(WR_C, REC_C), max2(RD_C, REL_C));
  localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sel_q, oe_q, we_q, drv_q, rsp_q;
  logic              tmr_load, tmr_done, accept, sample;
  logic [CNT_W-1:0]  tmr_val;

  assign req_ready_o = (phase_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign sample      = (phase_q == ST_RACC) && tmr_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      ST_IDLE:   if (accept) begin
                   tmr_load = 1'b1;
                   tmr_val  = req_write_i ? CNT_W'(WR_C - 1) : CNT_W'(RD_C - 1);
                 end
      ST_WPULSE: if (tmr_done) begin
                   tmr_load = 1'b1;
                   tmr_val  = CNT_W'(REC_C - 1);
                 end
      ST_RACC:   if (tmr_done) begin
                   tmr_load = 1'b1;
                   tmr_val  = CNT_W'(REL_C - 1);
                 end
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      sel_q   <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      drv_q   <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (phase_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          sel_q   <= 1'b1;
          if (req_write_i) begin
            we_q    <= 1'b1;
            drv_q   <= 1'b1;
            phase_q <= ST_WPULSE;
          end else begin
            oe_q    <= 1'b1;
            phase_q <= ST_RACC;
          end
        end
        ST_WPULSE: if (tmr_done) begin
          we_q    <= 1'b0;
          phase_q <= ST_WREC;
        end
        ST_WREC: if (tmr_done) begin
          sel_q   <= 1'b0;
          drv_q   <= 1'b0;
          phase_q <= ST_IDLE;
        end
        ST_RACC: if (tmr_done) begin
          sel_q   <= 1'b0;
          oe_q    <= 1'b0;
          rsp_q   <= 1'b1;
          phase_q <= ST_RTURN;
        end
        ST_RTURN: if (tmr_done) phase_q <= ST_IDLE;
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_data_port #(.DATA_W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .drive_i  (drv_q),
    .wdata_i  (wdata_q),
    .sample_i (sample),
    .rdata_o  (rsp_rdata_o),
    .bus_io   (sram_data_io)
  );

  assign sram_addr_o = addr_q;
  assign sram_ce1_no = ~sel_q;
  assign sram_ce2_o  = sel_q;
  assign sram_oe_no  = ~oe_q;
  assign sram_we_no  = ~we_q;
  assign rsp_valid_o = rsp_q;

  // write-low run length, checker state only
  logic [CNT_W:0] we_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 we_run_q <= '0;
    else if (sram_we_no)                         we_run_q <= '0;
    else if (we_run_q != {(CNT_W+1){1'b1}})      we_run_q <= we_run_q + 1'b1;
  end

  // R3
  we_needs_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce1_no && sram_ce2_o && sram_oe_no));

  // R3
  we_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (int'(we_run_q) >= WR_C));

  // R6
  rsp_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R7
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce1_no |-> !req_ready_o);

  // R8
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> sram_oe_no);

  // R8
  read_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |=> (!drv_q && sram_ce1_no));

  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce1_no && $past(!sram_ce1_no)) |-> $stable(sram_addr_o));

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          ce1_n, ce2, oe_n, we_n;
  wire  [DW-1:0] sram_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_write_i  (req_write),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .rsp_valid_o  (rsp_valid),
    .rsp_rdata_o  (rsp_rdata),
    .sram_addr_o  (sram_addr),
    .sram_ce1_no  (ce1_n),
    .sram_ce2_o   (ce2),
    .sram_oe_no   (oe_n),
    .sram_we_no   (we_n),
    .sram_data_io (sram_data)
  );

  // memory model: poison byte on the first cycle of an output enable
  logic [DW-1:0] mem [0:1023];
  logic          oe_seen;
  wire           mdl_sel = !ce1_n && ce2;
  wire           mdl_rd  = mdl_sel && !oe_n && we_n;

  always @(posedge clk) oe_seen <= mdl_rd;
  assign sram_data = mdl_rd ? (oe_seen ? mem[sram_addr[9:0]] : 8'hEE) : {DW{1'bz}};
  always @(posedge we_n) if (mdl_sel) mem[sram_addr[9:0]] = sram_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pins(input string req, input logic sel, input logic oe_low,
                          input logic we_low, input logic rdy);
    chk(req, {28'd0, ce1_n, ce2, oe_n, we_n}, {28'd0, !sel, sel, !oe_low, !we_low});
    chk(req, {31'd0, req_ready}, {31'd0, rdy});
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_pins("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1 rsp in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pins("R1 after reset", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1 rsp after reset", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic test_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    chk_pins("R3 write cycle 1", 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R3 write addr", {15'd0, sram_addr}, {15'd0, a});
    chk("R3 write data", {24'd0, sram_data}, {24'd0, d});
    @(negedge clk);
    chk_pins("R3 write cycle 2", 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk_pins("R4 recovery", 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4 data hold", {24'd0, sram_data}, {24'd0, d});
    chk("R9 addr hold", {15'd0, sram_addr}, {15'd0, a});
    @(negedge clk);
    chk_pins("R2 R7 write done", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 stored", {24'd0, mem[a[9:0]]}, {24'd0, d});
  endtask

  task automatic test_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    issue(1'b0, a, 8'h00);
    chk_pins("R5 read cycle 1", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5 read addr", {15'd0, sram_addr}, {15'd0, a});
    chk("R6 no early rsp", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk_pins("R5 read cycle 2", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk_pins("R6 R8 turnaround", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 rsp valid", {31'd0, rsp_valid}, 32'd1);
    chk("R6 rsp data", {24'd0, rsp_rdata}, {24'd0, exp});
    @(negedge clk);
    chk_pins("R7 read done", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 rsp one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic test_write_then_read(input logic [AW-1:0] a, input logic [DW-1:0] d);
    test_write(a, d);
    // R8: deselected idle cycle observed above before the read's enable falls
    chk("R8 gap before read", {31'd0, oe_n}, 32'd1);
    test_read(a, d);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    test_reset();
    test_write(17'h00000, 8'h5A);
    test_write(17'h1FFFF, 8'hA5);
    test_read(17'h1FFFF, 8'hA5);
    test_read(17'h00000, 8'h5A);
    test_write_then_read(17'h00155, 8'h3C);
    test_read(17'h0AAAA, 8'h00);
    test_write(17'h0AAAA, 8'hC3);
    test_read(17'h0AAAA, 8'hC3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule